// File: doc/BRIEF.md
# Randomised Root Contention Resolver

This block is the per-node state machine that settles a tie when both ends of a link each try to make the other its parent. Each end announces idle and tosses a coin to pick a short or a long waiting window. It counts tick pulses while it waits, then acts on the last symbol it heard from the peer. If the peer is still requesting when the window opens, the node acknowledges and becomes root. If the peer has gone idle, the node sends its own request. It then becomes child if the peer acknowledges, or starts a fresh attempt if the peer requests at the same time.

The received-symbol inputs are one-cycle events decoded by the link layer. The send outputs are one-cycle registered strobes for the link transmitter. The random bit comes from an external source and is sampled only in the cycle a window is chosen. Root and child are final: the node stays there until the next synchronous reset.

Top module: `rootsel_node`

## Requirements
- R1: While `rst` is high at a clock edge, the node returns to the contention state with its timer cleared. In the cycle after that edge, all send strobes and both final indications are 0.
- R2: In contention with no `rx_idle`, or in peer-idle-seen with no `rx_req`, the node pulses `tx_idle` for one cycle after the edge and clears its timer. `coin` is sampled in that cycle only: 0 selects the short window and 1 selects the long window. From contention the node waits with the peer assumed requesting. From peer-idle-seen it waits with the peer assumed idle. At most one send strobe is high in any cycle.
- R3: In contention, `rx_idle` moves the node to peer-idle-seen and nothing is sent. In peer-idle-seen, `rx_req` moves it back to contention and nothing is sent.
- R4: While waiting, the timer advances by one only in cycles with `tick` high, and only while it is below the act point. The window opens when the timer equals the act point. The defaults are 85 for the short window (lower bound 76) and 167 for the long window (lower bound 159). The timer never exceeds the upper bound of the window in use.
- R5: While waiting with the peer requesting, `rx_idle` switches to waiting with the peer idle. While waiting with the peer idle, `rx_req` switches back. A switch keeps the window choice and the timer value.
- R6: When the window is open and the peer is requesting, with no `rx_idle` that cycle, the node pulses `tx_ack` and raises `is_root` in the same following cycle.
- R7: When the window is open and the peer is idle, with no `rx_req` that cycle, the node pulses `tx_req` and enters request-sent.
- R8: In request-sent, `rx_req` returns the node to contention, and it takes priority over `rx_ack`. `rx_ack` alone makes the node child, so `is_child` rises.
- R9: Root and child are terminal. Only one of `is_root` and `is_child` can be high, and neither changes until reset. No send strobe fires while either is high, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Time-unit pulse that advances the wait timer |
| coin | input | 1 | Random bit: 0 short window, 1 long window |
| rx_idle | input | 1 | Idle symbol received from the peer |
| rx_req | input | 1 | Request symbol received from the peer |
| rx_ack | input | 1 | Acknowledge symbol received from the peer |
| tx_idle | output | 1 | Send idle strobe |
| tx_req | output | 1 | Send request strobe |
| tx_ack | output | 1 | Send acknowledge strobe |
| is_root | output | 1 | Node has become root |
| is_child | output | 1 | Node has become child |

## Verification
Directed runs use a steady peer request with each coin value. They separate the 85-tick and 167-tick act points exactly and show the window opening and the root decision. A peer that goes idle first, then acknowledges or counter-requests, separates the child outcome from the retry. A run with `tick` held low for a stretch shows that waiting counts ticks and not clock cycles. Random runs with sparse peer symbols and gappy ticks mix in mid-window direction switches, same-cycle symbol collisions and repeated attempts, and each outcome is compared cycle by cycle against a bench model.

// File: rtl/rootsel_pkg.sv
package rootsel_pkg;

    typedef enum logic [3:0] {
        ST_CONTEND   = 4'd0,
        ST_PEER_IDLE = 4'd1,
        ST_WREQ_FAST = 4'd2,
        ST_WREQ_SLOW = 4'd3,
        ST_WIDL_FAST = 4'd4,
        ST_WIDL_SLOW = 4'd5,
        ST_REQ_SENT  = 4'd6,
        ST_ROOT      = 4'd7,
        ST_CHILD     = 4'd8
    } node_st_e;

    typedef struct packed {
        node_st_e st;
        logic     snd_idle;
        logic     snd_req;
        logic     snd_ack;
    } node_fsm_t;

endpackage

// File: rtl/rootsel_timer.sv
module rootsel_timer #(
    parameter int SAT = 168,
    parameter int W   = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && (cnt_q != W'(SAT))) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/rootsel_window.sv
module rootsel_window #(
    parameter int FAST_MIN = 76,
    parameter int FAST_MAX = 85,
    parameter int SLOW_MIN = 159,
    parameter int SLOW_MAX = 167,
    parameter int FAST_ACT = FAST_MAX,
    parameter int SLOW_ACT = SLOW_MAX,
    parameter int W        = 8
) (
    input  logic         slow_sel,
    input  logic [W-1:0] tmr,
    output logic         open,
    output logic         below
);
    // Act points are clamped into their window so the upper bound holds.
    localparam int FAST_PT = (FAST_ACT < FAST_MIN) ? FAST_MIN :
                             (FAST_ACT > FAST_MAX) ? FAST_MAX : FAST_ACT;
    localparam int SLOW_PT = (SLOW_ACT < SLOW_MIN) ? SLOW_MIN :
                             (SLOW_ACT > SLOW_MAX) ? SLOW_MAX : SLOW_ACT;

    logic [W-1:0] act_pt;

    always_comb begin
        act_pt = slow_sel ? W'(SLOW_PT) : W'(FAST_PT);
        open   = (tmr >= act_pt);
        below  = (tmr <  act_pt);
    end
endmodule

// File: rtl/rootsel_node.sv
module rootsel_node
    import rootsel_pkg::*;
#(
    parameter int FAST_MIN = 76,
    parameter int FAST_MAX = 85,
    parameter int SLOW_MIN = 159,
    parameter int SLOW_MAX = 167,
    parameter int FAST_ACT = FAST_MAX,
    parameter int SLOW_ACT = SLOW_MAX,
    parameter int TMR_SAT  = 168
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic coin,
    input  logic rx_idle,
    input  logic rx_req,
    input  logic rx_ack,
    output logic tx_idle,
    output logic tx_req,
    output logic tx_ack,
    output logic is_root,
    output logic is_child
);
    localparam int TMR_W = $clog2(TMR_SAT + 1);

    node_fsm_t          fsm_d, fsm_q;
    logic [TMR_W-1:0]   tmr;
    logic               tmr_clr, tmr_inc;
    logic               win_open, win_below;
    logic               is_slow, in_wait;

    always_comb begin
        is_slow = (fsm_q.st == ST_WREQ_SLOW) || (fsm_q.st == ST_WIDL_SLOW);
        in_wait = (fsm_q.st == ST_WREQ_FAST) || (fsm_q.st == ST_WREQ_SLOW) ||
                  (fsm_q.st == ST_WIDL_FAST) || (fsm_q.st == ST_WIDL_SLOW);
    end

    rootsel_window #(
        .FAST_MIN (FAST_MIN),
        .FAST_MAX (FAST_MAX),
        .SLOW_MIN (SLOW_MIN),
        .SLOW_MAX (SLOW_MAX),
        .FAST_ACT (FAST_ACT),
        .SLOW_ACT (SLOW_ACT),
        .W        (TMR_W)
    ) u_window (
        .slow_sel (is_slow),
        .tmr      (tmr),
        .open     (win_open),
        .below    (win_below)
    );

    rootsel_timer #(
        .SAT (TMR_SAT),
        .W   (TMR_W)
    ) u_timer (
        .clk (clk),
        .rst (rst),
        .clr (tmr_clr),
        .inc (tmr_inc),
        .cnt (tmr)
    );

    always_comb begin
        fsm_d          = fsm_q;
        fsm_d.snd_idle = 1'b0;
        fsm_d.snd_req  = 1'b0;
        fsm_d.snd_ack  = 1'b0;
        tmr_clr        = 1'b0;
        tmr_inc        = 1'b0;
        unique case (fsm_q.st)
            ST_CONTEND: begin
                if (rx_idle) begin
                    fsm_d.st = ST_PEER_IDLE;
                end else begin
                    fsm_d.snd_idle = 1'b1;
                    tmr_clr        = 1'b1;
                    fsm_d.st       = coin ? ST_WREQ_SLOW : ST_WREQ_FAST;
                end
            end
            ST_PEER_IDLE: begin
                if (rx_req) begin
                    fsm_d.st = ST_CONTEND;
                end else begin
                    fsm_d.snd_idle = 1'b1;
                    tmr_clr        = 1'b1;
                    fsm_d.st       = coin ? ST_WIDL_SLOW : ST_WIDL_FAST;
                end
            end
            ST_WREQ_FAST, ST_WREQ_SLOW: begin
                if (rx_idle) begin
                    fsm_d.st = is_slow ? ST_WIDL_SLOW : ST_WIDL_FAST;
                    tmr_inc  = tick && win_below;
                end else if (win_open) begin
                    fsm_d.snd_ack = 1'b1;
                    tmr_clr       = 1'b1;
                    fsm_d.st      = ST_ROOT;
                end else begin
                    tmr_inc = tick && win_below;
                end
            end
            ST_WIDL_FAST, ST_WIDL_SLOW: begin
                if (rx_req) begin
                    fsm_d.st = is_slow ? ST_WREQ_SLOW : ST_WREQ_FAST;
                    tmr_inc  = tick && win_below;
                end else if (win_open) begin
                    fsm_d.snd_req = 1'b1;
                    tmr_clr       = 1'b1;
                    fsm_d.st      = ST_REQ_SENT;
                end else begin
                    tmr_inc = tick && win_below;
                end
            end
            ST_REQ_SENT: begin
                if (rx_req) begin
                    fsm_d.st = ST_CONTEND;
                end else if (rx_ack) begin
                    fsm_d.st = ST_CHILD;
                end
            end
            ST_ROOT, ST_CHILD: begin
                fsm_d.st = fsm_q.st;
            end
            default: begin
                fsm_d.st = ST_CONTEND;
                tmr_clr  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q.st       <= ST_CONTEND;
            fsm_q.snd_idle <= 1'b0;
            fsm_q.snd_req  <= 1'b0;
            fsm_q.snd_ack  <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign tx_idle  = fsm_q.snd_idle;
    assign tx_req   = fsm_q.snd_req;
    assign tx_ack   = fsm_q.snd_ack;
    assign is_root  = (fsm_q.st == ST_ROOT);
    assign is_child = (fsm_q.st == ST_CHILD);
endmodule

// File: rtl/rootsel_chk.sv
module rootsel_chk #(
    parameter int W        = 8,
    parameter int FAST_LIM = 85,
    parameter int SLOW_LIM = 167
) (
    input logic         clk,
    input logic         rst,
    input logic         rx_ack,
    input logic         tx_idle,
    input logic         tx_req,
    input logic         tx_ack,
    input logic         is_root,
    input logic         is_child,
    input logic [W-1:0] tmr,
    input logic         in_wait,
    input logic         slow_wait
);
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_idle, tx_req, tx_ack}));

    p_fast_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (in_wait && !slow_wait) |-> (tmr <= W'(FAST_LIM)));

    p_slow_bound_r4: assert property (@(posedge clk) disable iff (rst)
        (in_wait && slow_wait) |-> (tmr <= W'(SLOW_LIM)));

    p_ack_root_r6: assert property (@(posedge clk) disable iff (rst)
        tx_ack |-> is_root);

    p_req_open_r7: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> (!is_root && !is_child && !in_wait));

    p_child_ack_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(is_child) |-> $past(rx_ack));

    p_root_hold_r9: assert property (@(posedge clk) disable iff (rst)
        is_root |=> (is_root && !tx_idle && !tx_req && !tx_ack));

    p_child_hold_r9: assert property (@(posedge clk) disable iff (rst)
        is_child |=> (is_child && !tx_idle && !tx_req && !tx_ack));

    p_final_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(is_root && is_child));
endmodule

bind rootsel_node rootsel_chk #(
    .W        (TMR_W),
    .FAST_LIM (FAST_MAX),
    .SLOW_LIM (SLOW_MAX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_ack    (rx_ack),
    .tx_idle   (tx_idle),
    .tx_req    (tx_req),
    .tx_ack    (tx_ack),
    .is_root   (is_root),
    .is_child  (is_child),
    .tmr       (tmr),
    .in_wait   (in_wait),
    .slow_wait (is_slow)
);

// File: tb/rootsel_node_bench.sv
`timescale 1ns/1ps
module rootsel_node_bench;
    localparam int FAST_PT = 85;
    localparam int SLOW_PT = 167;

    logic clk = 1'b0;
    logic rst, tick, coin, rx_idle, rx_req, rx_ack;
    logic tx_idle, tx_req, tx_ack, is_root, is_child;

    int n_chk = 0;
    int n_bad = 0;

    // bench model: 0 contend, 1 peer idle, 2/3 wait-req fast/slow,
    // 4/5 wait-idle fast/slow, 6 request sent, 7 root, 8 child
    int    m_st  = 0;
    int    m_tmr = 0;
    logic  e_idle = 0, e_req = 0, e_ack = 0;
    string m_tag = "R1";

    always #5 clk = ~clk;

    rootsel_node u_rootsel_node (
        .clk(clk), .rst(rst), .tick(tick), .coin(coin),
        .rx_idle(rx_idle), .rx_req(rx_req), .rx_ack(rx_ack),
        .tx_idle(tx_idle), .tx_req(tx_req), .tx_ack(tx_ack),
        .is_root(is_root), .is_child(is_child)
    );

    function automatic void model(bit r, bit tk, bit cn, bit ri, bit rq, bit ra);
        int lim;
        e_idle = 0; e_req = 0; e_ack = 0;
        if (r) begin
            m_st = 0; m_tmr = 0; m_tag = "R1";
            return;
        end
        case (m_st)
            0: if (ri) begin m_st = 1; m_tag = "R3"; end
               else begin e_idle = 1; m_tmr = 0; m_st = cn ? 3 : 2; m_tag = "R2"; end
            1: if (rq) begin m_st = 0; m_tag = "R3"; end
               else begin e_idle = 1; m_tmr = 0; m_st = cn ? 5 : 4; m_tag = "R2"; end
            2, 3: begin
                lim = (m_st == 3) ? SLOW_PT : FAST_PT;
                if (ri) begin
                    m_st = m_st + 2; if (tk && m_tmr < lim) m_tmr++; m_tag = "R5";
                end else if (m_tmr >= lim) begin
                    e_ack = 1; m_st = 7; m_tmr = 0; m_tag = "R6";
                end else begin
                    if (tk) m_tmr++; m_tag = "R4";
                end
            end
            4, 5: begin
                lim = (m_st == 5) ? SLOW_PT : FAST_PT;
                if (rq) begin
                    m_st = m_st - 2; if (tk && m_tmr < lim) m_tmr++; m_tag = "R5";
                end else if (m_tmr >= lim) begin
                    e_req = 1; m_st = 6; m_tmr = 0; m_tag = "R7";
                end else begin
                    if (tk) m_tmr++; m_tag = "R4";
                end
            end
            6: begin
                if (rq) m_st = 0; else if (ra) m_st = 8;
                m_tag = "R8";
            end
            default: m_tag = "R9";
        endcase
    endfunction

    task automatic check_out();
        logic [4:0] got, exp;
        got = {tx_idle, tx_req, tx_ack, is_root, is_child};
        exp = {e_idle, e_req, e_ack, (m_st == 7), (m_st == 8)};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: outputs {idle,req,ack,root,child} = %b, expected %b at %0t",
                     m_tag, got, exp, $time);
        end
    endtask

    task automatic step(bit r, bit tk, bit cn, bit ri, bit rq, bit ra);
        rst = r; tick = tk; coin = cn; rx_idle = ri; rx_req = rq; rx_ack = ra;
        model(r, tk, cn, ri, rq, ra);
        @(negedge clk);
        check_out();
    endtask

    task automatic idle_cycles(int n, bit tk);
        for (int i = 0; i < n; i++) step(0, tk, 0, 0, 0, 0);
    endtask

    task automatic do_reset();
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'h5eed_1234);

        // R1 reset state, then R2/R4/R6 short window to root
        do_reset();
        step(0, 1, 0, 0, 0, 0);          // idle sent, short window, peer requesting
        idle_cycles(FAST_PT + 4, 1);     // R6 ack at exact act point
        step(0, 1, 1, 1, 1, 1);          // R9 inputs ignored once root
        idle_cycles(5, 1);

        // R2 long window to root
        do_reset();
        step(0, 1, 1, 0, 0, 0);
        idle_cycles(SLOW_PT + 4, 1);

        // R4 ticks gated: 30 cycles without tick hold the timer
        do_reset();
        step(0, 1, 0, 0, 0, 0);
        idle_cycles(40, 1);
        idle_cycles(30, 0);
        idle_cycles(FAST_PT, 1);

        // R3 peer idle before choice, R7 request, R8 child
        do_reset();
        step(0, 1, 0, 1, 0, 0);          // contend -> peer idle
        step(0, 1, 0, 0, 1, 0);          // peer idle -> contend
        step(0, 1, 0, 1, 0, 0);          // contend -> peer idle
        step(0, 1, 0, 0, 0, 0);          // idle sent, waiting with peer idle
        idle_cycles(FAST_PT + 2, 1);     // R7 request sent
        step(0, 1, 0, 0, 1, 1);          // R8 request wins over ack -> contend
        step(0, 1, 0, 0, 0, 0);          // retry
        step(0, 1, 0, 1, 0, 0);          // R5 switch to peer idle
        idle_cycles(FAST_PT + 2, 1);
        idle_cycles(3, 1);
        step(0, 1, 0, 0, 0, 1);          // R8 child
        idle_cycles(4, 1);

        // R5 switch back and forth mid-window, long window
        do_reset();
        step(0, 1, 1, 0, 0, 0);
        idle_cycles(50, 1);
        step(0, 1, 0, 1, 0, 0);
        idle_cycles(20, 1);
        step(0, 1, 0, 0, 1, 0);
        idle_cycles(SLOW_PT, 1);

        // random episodes
        for (int ep = 0; ep < 60; ep++) begin
            do_reset();
            for (int c = 0; c < 700; c++) begin
                int unsigned rv;
                bit ri, rq, ra;
                rv = $urandom;
                ri = (rv[5:0] == 6'd1) || (rv[5:0] == 6'd2);
                rq = (rv[11:6] == 6'd3) || (rv[11:6] == 6'd4);
                ra = (rv[17:12] == 6'd5) || (rv[17:12] == 6'd6);
                step(0, rv[20:18] != 3'd0, rv[21], ri, rq, ra);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule